// File: doc/BRIEF.md
# Sliding Window Exponent Partitioner

This block takes an exponent of up to `EXP_W` bits and cuts it into the windows that a sliding-window exponentiation engine consumes. It reads the exponent one bit per cycle, starting at the top bit in use. Each window it completes is handed out on a valid/ready stream. A window is either a run of zeros of any length, or a nonzero group that starts and ends with a 1. Runs of zeros shorter than a threshold can sit inside a nonzero group. No powers are computed here: the block only decides where the cuts fall.

Software-visible values are not involved. A controller presents the exponent, the number of low bits in use, the window limit `k` and the zero-run threshold `q`, then pulses `start`. It drains the window stream and waits for `done`. Back-pressure is simple. A window on the output stays fixed until `win_ready` is seen high at a clock edge with `win_valid` high. While the window waits, the scan stalls, so no window is dropped and none is repeated. Full throughput is one window per cycle with `win_ready` held high.

Top module: `swp_partitioner`

## Requirements
- R1: Bits are scanned from bit `exp_len-1` down to bit 0. Concatenating the emitted windows, most significant first, gives exactly the bits from the highest 1 down to bit 0.
- R2: Zeros above the highest 1 are skipped and produce no window. The first window of a run is always nonzero.
- R3: A zero window has `win_nz`=0, `win_value`=0 and a length of at least 1, and it may be as long as the exponent allows. Two zero windows are never emitted back to back.
- R4: A nonzero window has `win_nz`=1. Its value is odd and fits in `win_len` bits, with its top bit set, so it both starts and ends with a 1.
- R5: A nonzero window is never longer than `k` bits. When an open nonzero group reaches `k` bits it is closed. Any trailing zeros are cut off and become the start of the following zero window. With no trailing zeros, the scan stays in nonzero mode.
- R6: When `q` consecutive zeros are collected inside an open nonzero group, the group closes at its last 1. Those `q` zeros open a zero window, which then extends over any further zeros.
- R7: After bit 0 the open window is flushed. An open nonzero group is emitted trimmed to its last 1, and any zeros after it are emitted as one final zero window.
- R8: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse that comes after the last window has been accepted. A `start` seen while `busy` is high is ignored.
- R9: If no 1 exists among the bits in use, no window is emitted and `all_zero` is high together with `done`. Otherwise `all_zero` is low. The value holds until the next accepted `start`.
- R10: While `win_valid` is high and `win_ready` is low, `win_valid`, `win_value`, `win_len` and `win_nz` stay unchanged.
- R11: `exp_in`, `exp_len`, `k_cfg` and `q_cfg` are sampled only at an accepted `start`. Bits of `exp_in` at or above `exp_len` are ignored. A `k_cfg` below 2 acts as 2 and one above `KMAX` acts as `KMAX`. A `q_cfg` of 0 acts as 1 and one above `QMAX` acts as `QMAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a partition run (taken only when idle) |
| exp_in | input | EXP_W | Exponent value |
| exp_len | input | LENW | Number of low exponent bits in use |
| k_cfg | input | CNTW | Largest nonzero window length |
| q_cfg | input | QW | Zero-run length that ends a nonzero group |
| busy | output | 1 | A run is in progress |
| win_valid | output | 1 | A window is offered |
| win_ready | input | 1 | Consumer accepts the offered window |
| win_value | output | KMAX | Window bits, right aligned (0 for zero windows) |
| win_len | output | LENW | Window length in bits |
| win_nz | output | 1 | 1 for a nonzero window, 0 for a zero window |
| done | output | 1 | One-cycle pulse at the end of a run |
| all_zero | output | 1 | Last run found no 1 bit |

## Verification
The hardest case to reach is a nonzero group that hits the `k` limit while it ends in zeros, especially when the `q` rule fires in the same bit. Then a single step has to trim the group and seed a zero window with the trimmed zeros. Directed exponents such as `10001001` with `k`=4 are built to land the limit on a zero, and `k`=`q` cases make both rules fire together. Every run is compared on each clock against a behavioural model of the cut rules. The consumer's ready line is driven in three patterns: always ready, random, and mostly stalled. This makes closes, flushes and `done` happen while a window is held back.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // Run phase of the partitioner
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCAN  = 2'd1,
    PH_FLUSH = 2'd2,
    PH_FIN   = 2'd3
  } swp_phase_e;

endpackage

// File: rtl/swp_bit_feeder.sv
// Holds the exponent left-aligned and yields one bit per take, MSB first.
module swp_bit_feeder #(
  parameter int EXP_W = 32,
  parameter int LENW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             take,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [LENW-1:0]  exp_len,
  output logic             bit_out,
  output logic             empty
);

  logic [EXP_W-1:0] sh_q;
  logic [LENW-1:0]  rem_q;
  logic [LENW-1:0]  len_c;
  logic [LENW-1:0]  pad;

  always_comb begin
    len_c = (32'(exp_len) > EXP_W) ? LENW'(EXP_W) : exp_len;
    pad   = LENW'(EXP_W) - len_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= exp_in << pad;
      rem_q <= len_c;
    end else if (take && (rem_q != '0)) begin
      sh_q  <= sh_q << 1;
      rem_q <= rem_q - LENW'(1);
    end
  end

  assign bit_out = sh_q[EXP_W-1];
  assign empty   = (rem_q == '0);

endmodule

// File: rtl/swp_window_core.sv
// Two-mode window builder: zero-run mode and nonzero-group mode.
module swp_window_core #(
  parameter int KMAX = 8,
  parameter int LENW = 6,
  parameter int CNTW = 4,
  parameter int QW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            scan_step,
  input  logic            flush_step,
  input  logic            bit_in,
  input  logic [CNTW-1:0] k_lim,
  input  logic [QW-1:0]   q_lim,
  output logic            emit,
  output logic [KMAX-1:0] emit_val,
  output logic [LENW-1:0] emit_len,
  output logic            emit_nz,
  output logic            drained,
  output logic            seen_one
);

  logic            nz_q, nz_d;
  logic            seen_q, seen_d;
  logic [KMAX-1:0] val_q, val_d;
  logic [CNTW-1:0] len_q, len_d;
  logic [CNTW-1:0] tz_q, tz_d;
  logic [LENW-1:0] zc_q, zc_d;

  logic [KMAX-1:0] cat_val;
  logic [CNTW-1:0] cat_len;
  logic [CNTW-1:0] cat_tz;
  logic            close;

  always_comb begin
    cat_val = {val_q[KMAX-2:0], bit_in};
    cat_len = len_q + CNTW'(1);
    cat_tz  = bit_in ? '0 : (tz_q + CNTW'(1));
    close   = (32'(cat_tz) == 32'(q_lim)) || (cat_len == k_lim);
  end

  always_comb begin
    nz_d     = nz_q;
    seen_d   = seen_q;
    val_d    = val_q;
    len_d    = len_q;
    tz_d     = tz_q;
    zc_d     = zc_q;
    emit     = 1'b0;
    emit_val = '0;
    emit_len = '0;
    emit_nz  = 1'b0;
    drained  = 1'b0;
    if (clear) begin
      nz_d   = 1'b0;
      seen_d = 1'b0;
      val_d  = '0;
      len_d  = '0;
      tz_d   = '0;
      zc_d   = '0;
    end else if (scan_step) begin
      if (!nz_q) begin
        if (bit_in) begin
          if (zc_q != '0) begin
            emit     = 1'b1;
            emit_len = zc_q;
          end
          nz_d   = 1'b1;
          seen_d = 1'b1;
          val_d  = KMAX'(1);
          len_d  = CNTW'(1);
          tz_d   = '0;
          zc_d   = '0;
        end else if (seen_q) begin
          zc_d = zc_q + LENW'(1);
        end
      end else if (len_q == '0) begin
        // nonzero mode with no open group (after a k-limit close ending in 1)
        if (bit_in) begin
          val_d = KMAX'(1);
          len_d = CNTW'(1);
          tz_d  = '0;
        end else begin
          nz_d = 1'b0;
          zc_d = LENW'(1);
        end
      end else if (close) begin
        emit     = 1'b1;
        emit_nz  = 1'b1;
        emit_val = cat_val >> cat_tz;
        emit_len = LENW'(cat_len - cat_tz);
        val_d    = '0;
        len_d    = '0;
        tz_d     = '0;
        if (cat_tz != '0) begin
          nz_d = 1'b0;
          zc_d = LENW'(cat_tz);
        end
      end else begin
        val_d = cat_val;
        len_d = cat_len;
        tz_d  = cat_tz;
      end
    end else if (flush_step) begin
      if (nz_q && (len_q != '0)) begin
        emit     = 1'b1;
        emit_nz  = 1'b1;
        emit_val = val_q >> tz_q;
        emit_len = LENW'(len_q - tz_q);
        nz_d     = 1'b0;
        zc_d     = LENW'(tz_q);
        val_d    = '0;
        len_d    = '0;
        tz_d     = '0;
      end else if (zc_q != '0) begin
        emit     = 1'b1;
        emit_len = zc_q;
        zc_d     = '0;
      end else begin
        drained = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q   <= 1'b0;
      seen_q <= 1'b0;
      val_q  <= '0;
      len_q  <= '0;
      tz_q   <= '0;
      zc_q   <= '0;
    end else begin
      nz_q   <= nz_d;
      seen_q <= seen_d;
      val_q  <= val_d;
      len_q  <= len_d;
      tz_q   <= tz_d;
      zc_q   <= zc_d;
    end
  end

  assign seen_one = seen_q;

endmodule

// File: rtl/swp_out_slot.sv
// Single output register of the window stream.
module swp_out_slot #(
  parameter int KMAX = 8,
  parameter int LENW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [KMAX-1:0] in_val,
  input  logic [LENW-1:0] in_len,
  input  logic            in_nz,
  input  logic            ready,
  output logic            valid,
  output logic [KMAX-1:0] val,
  output logic [LENW-1:0] len,
  output logic            nz
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      val   <= '0;
      len   <= '0;
      nz    <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      val   <= in_val;
      len   <= in_len;
      nz    <= in_nz;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/swp_partitioner.sv
module swp_partitioner
  import swp_pkg::*;
#(
  parameter  int EXP_W = 32,
  parameter  int KMAX  = 8,
  parameter  int QMAX  = 5,
  localparam int LENW  = $clog2(EXP_W + 1),
  localparam int CNTW  = $clog2(KMAX + 1),
  localparam int QW    = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EXP_W-1:0] exp_in,
  input  logic [LENW-1:0]  exp_len,
  input  logic [CNTW-1:0]  k_cfg,
  input  logic [QW-1:0]    q_cfg,
  output logic             busy,
  output logic             win_valid,
  input  logic             win_ready,
  output logic [KMAX-1:0]  win_value,
  output logic [LENW-1:0]  win_len,
  output logic             win_nz,
  output logic             done,
  output logic             all_zero
);

  swp_phase_e      phase_q;
  logic [CNTW-1:0] k_q;
  logic [QW-1:0]   q_q;
  logic [CNTW-1:0] k_c;
  logic [QW-1:0]   q_c;
  logic            done_q;
  logic            allz_q;

  logic            adv;
  logic            start_ok;
  logic            scan_step;
  logic            flush_step;
  logic            feed_bit;
  logic            feed_empty;
  logic            c_emit;
  logic [KMAX-1:0] c_val;
  logic [LENW-1:0] c_len;
  logic            c_nz;
  logic            c_drained;
  logic            c_seen;

  always_comb begin
    if (k_cfg < CNTW'(2))         k_c = CNTW'(2);
    else if (k_cfg > CNTW'(KMAX)) k_c = CNTW'(KMAX);
    else                          k_c = k_cfg;
    if (q_cfg == '0)              q_c = QW'(1);
    else if (q_cfg > QW'(QMAX))   q_c = QW'(QMAX);
    else                          q_c = q_cfg;
  end

  assign adv        = !win_valid || win_ready;
  assign start_ok   = start && (phase_q == PH_IDLE);
  assign scan_step  = (phase_q == PH_SCAN) && adv && !feed_empty;
  assign flush_step = (phase_q == PH_FLUSH) && adv;

  swp_bit_feeder #(.EXP_W(EXP_W), .LENW(LENW)) u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_ok),
    .take    (scan_step),
    .exp_in  (exp_in),
    .exp_len (exp_len),
    .bit_out (feed_bit),
    .empty   (feed_empty)
  );

  swp_window_core #(.KMAX(KMAX), .LENW(LENW), .CNTW(CNTW), .QW(QW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .scan_step  (scan_step),
    .flush_step (flush_step),
    .bit_in     (feed_bit),
    .k_lim      (k_q),
    .q_lim      (q_q),
    .emit       (c_emit),
    .emit_val   (c_val),
    .emit_len   (c_len),
    .emit_nz    (c_nz),
    .drained    (c_drained),
    .seen_one   (c_seen)
  );

  swp_out_slot #(.KMAX(KMAX), .LENW(LENW)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (c_emit),
    .in_val (c_val),
    .in_len (c_len),
    .in_nz  (c_nz),
    .ready  (win_ready),
    .valid  (win_valid),
    .val    (win_value),
    .len    (win_len),
    .nz     (win_nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      k_q     <= CNTW'(2);
      q_q     <= QW'(1);
      done_q  <= 1'b0;
      allz_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_ok) begin
          phase_q <= PH_SCAN;
          k_q     <= k_c;
          q_q     <= q_c;
          allz_q  <= 1'b0;
        end
        PH_SCAN:  if (feed_empty) phase_q <= PH_FLUSH;
        PH_FLUSH: if (flush_step && c_drained) phase_q <= PH_FIN;
        PH_FIN: if (!win_valid) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
          allz_q  <= !c_seen;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign all_zero = allz_q;

endmodule

// File: rtl/swp_partitioner_chk.sv
module swp_partitioner_chk #(
  parameter int KMAX = 8,
  parameter int LENW = 6,
  parameter int CNTW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            win_valid,
  input logic            win_ready,
  input logic [KMAX-1:0] win_value,
  input logic [LENW-1:0] win_len,
  input logic            win_nz,
  input logic            done,
  input logic            busy,
  input logic [CNTW-1:0] k_lim
);

  logic prev_nz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_nz_q <= 1'b0;
    else if (win_valid && win_ready) prev_nz_q <= win_nz;
  end

  a_r4_nz_odd: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && win_nz |-> win_value[0]);

  a_r4_nz_fits: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && win_nz |-> (win_len != '0) && ((32'(win_value) >> win_len) == 0)
                          && ((32'(win_value) >> (win_len - LENW'(1))) == 1));

  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && win_nz |-> 32'(win_len) <= 32'(k_lim));

  a_r3_zero_shape: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !win_nz |-> (win_value == '0) && (win_len != '0));

  a_r3_no_double_zero: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && win_ready && !win_nz |-> prev_nz_q);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !win_ready |=> win_valid && $stable(win_value)
                               && $stable(win_len) && $stable(win_nz));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !win_valid && !busy);

  a_r8_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> busy);

endmodule

bind swp_partitioner swp_partitioner_chk #(.KMAX(KMAX), .LENW(LENW), .CNTW(CNTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_valid (win_valid),
  .win_ready (win_ready),
  .win_value (win_value),
  .win_len   (win_len),
  .win_nz    (win_nz),
  .done      (done),
  .busy      (busy),
  .k_lim     (k_q)
);

// File: tb/swp_partitioner_tb.sv
`timescale 1ns/1ps
module swp_partitioner_tb;

  localparam int EXP_W = 32;
  localparam int KMAX  = 8;
  localparam int QMAX  = 5;
  localparam int LENW  = $clog2(EXP_W + 1);
  localparam int CNTW  = $clog2(KMAX + 1);
  localparam int QW    = $clog2(QMAX + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [EXP_W-1:0] exp_in = '0;
  logic [LENW-1:0]  exp_len = '0;
  logic [CNTW-1:0]  k_cfg = CNTW'(4);
  logic [QW-1:0]    q_cfg = QW'(2);
  logic             win_ready = 1'b0;
  logic             busy, win_valid, win_nz, done, all_zero;
  logic [KMAX-1:0]  win_value;
  logic [LENW-1:0]  win_len;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  int mv[$];
  int ml[$];
  bit mn[$];
  bit m_az;

  always #4 clk = ~clk;

  swp_partitioner #(.EXP_W(EXP_W), .KMAX(KMAX), .QMAX(QMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in), .exp_len(exp_len),
    .k_cfg(k_cfg), .q_cfg(q_cfg), .busy(busy), .win_valid(win_valid),
    .win_ready(win_ready), .win_value(win_value), .win_len(win_len),
    .win_nz(win_nz), .done(done), .all_zero(all_zero)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural model of the cut rules, written over a bit array
  task automatic build(input logic [31:0] e, input int len, input int k, input int q);
    int p;
    mv.delete(); ml.delete(); mn.delete();
    if (k < 2) k = 2;
    if (k > KMAX) k = KMAX;
    if (q < 1) q = 1;
    if (q > QMAX) q = QMAX;
    p = len - 1;
    while (p >= 0 && e[p] == 1'b0) p--;
    m_az = (p < 0);
    while (p >= 0) begin
      if (e[p]) begin
        int cnt = 0;
        int run = 0;
        int v = 0;
        int j = p;
        while (j >= 0 && cnt < k && run < q) begin
          v = v * 2 + int'(e[j]);
          cnt++;
          run = e[j] ? 0 : run + 1;
          j--;
        end
        v = v >> run;
        mv.push_back(v); ml.push_back(cnt - run); mn.push_back(1'b1);
        p = p - (cnt - run);
      end else begin
        int z = 0;
        while (p >= 0 && e[p] == 1'b0) begin z++; p--; end
        mv.push_back(0); ml.push_back(z); mn.push_back(1'b0);
      end
    end
  endtask

  // mode: 0 always ready, 1 random, 2 mostly stalled
  task automatic run_case(input string tag, input logic [31:0] e, input int len,
                          input int k, input int q, input int mode, input bit poke);
    bit finished = 0;
    bit pstall = 0;
    logic [KMAX-1:0] pv = '0;
    logic [LENW-1:0] pl = '0;
    logic pn = 1'b0;
    build(e, len, k, q);
    @(negedge clk);
    exp_in = e; exp_len = LENW'(len); k_cfg = CNTW'(k); q_cfg = QW'(q);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
    for (int cyc = 0; cyc < 4000 && !finished; cyc++) begin
      @(negedge clk);
      if (poke && cyc == 2) begin
        start = 1'b1; exp_in = ~e; exp_len = LENW'(EXP_W);
        k_cfg = CNTW'(2); q_cfg = QW'(1);
      end
      if (poke && cyc == 3) start = 1'b0;
      case (mode)
        0: win_ready = 1'b1;
        1: win_ready = ($urandom % 3) != 0;
        default: win_ready = (cyc % 7) == 6;
      endcase
      #2;
      if (pstall) begin
        chk(win_valid === 1'b1 && win_value == pv && win_len == pl && win_nz == pn,
            "R10", "held window", int'(win_value), int'(pv));
      end
      if (win_valid && win_ready) begin
        if (mn.size() == 0) begin
          chk(1'b0, tag, "extra window", int'(win_len), 0);
        end else begin
          chk(win_nz == mn[0], tag, "R3/R4 kind", int'(win_nz), int'(mn[0]));
          chk(int'(win_len) == ml[0], tag, "R5 length", int'(win_len), ml[0]);
          chk(int'(win_value) == mv[0], tag, "R4 value", int'(win_value), mv[0]);
          void'(mv.pop_front()); void'(ml.pop_front()); void'(mn.pop_front());
        end
      end
      pstall = win_valid && !win_ready;
      pv = win_value; pl = win_len; pn = win_nz;
      if (done) begin
        chk(mn.size() == 0, "R8", "windows left at done", mn.size(), 0);
        chk(all_zero == m_az, "R9", "all_zero", int'(all_zero), int'(m_az));
        finished = 1;
      end
    end
    if (!finished) chk(1'b0, "R8", "done timeout", 0, 1);
    @(negedge clk);
    chk(all_zero == m_az, "R9", "all_zero held", int'(all_zero), int'(m_az));
    chk(busy === 1'b0 && done === 1'b0, "R8", "idle after done", int'(busy), 0);
    win_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R8", "reset busy", int'(busy), 0);
    chk(win_valid === 1'b0, "R10", "reset valid", int'(win_valid), 0);
    chk(done === 1'b0 && all_zero === 1'b0, "R9", "reset flags", int'(all_zero), 0);

    run_case("R1", 32'd1903, 12, 5, 2, 0, 0);
    run_case("R2", 32'h0000_00B5, 32, 4, 2, 0, 0);
    run_case("R9", 32'h0, 32, 4, 2, 0, 0);
    run_case("R9", 32'h0, 1, 4, 2, 1, 0);
    run_case("R5", 32'hFFFF_FFFF, 32, 4, 3, 0, 0);
    run_case("R5", 32'h0000_0089, 8, 4, 5, 0, 0);
    run_case("R5", 32'h0000_0211, 10, 4, 4, 2, 0);
    run_case("R6", 32'h9249_2492, 32, 8, 2, 0, 0);
    run_case("R6", 32'hA5A5_0F0F, 32, 8, 1, 1, 0);
    run_case("R7", 32'h0000_0058, 7, 8, 5, 0, 0);
    run_case("R3", 32'h8000_0001, 32, 8, 2, 2, 0);
    run_case("R10", 32'hDEAD_BEEF, 32, 5, 2, 2, 0);
    run_case("R10", 32'hC0FF_EE11, 32, 6, 3, 1, 0);
    run_case("R11", 32'hFFFF_F005, 10, 4, 2, 0, 1);
    run_case("R11", 32'h1234_5678, 32, 1, 0, 1, 0);
    run_case("R11", 32'h8765_4321, 32, 15, 7, 1, 0);
    for (int i = 0; i < 30; i++) begin
      run_case("R1", $urandom, 1 + ($urandom % 32), 2 + ($urandom % 7),
               1 + ($urandom % 5), i % 3, 0);
    end

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule